// File: doc/BRIEF.md
# Mux-Carry Ripple Adder with Signed Overflow

This block adds two K-bit operands and a carry-in. It returns the K-bit sum, the carry-out and a two's-complement overflow flag. It is purely combinational and holds no state. Every output follows the present inputs within one evaluation, with no clock.

Each bit position is a cell that forms a propagate term from the exchange of the two operand bits. That term steers a 2:1 multiplexer. When propagate is high, the cell passes its incoming carry upward. When propagate is low, the cell passes the second operand's bit, which then serves as the generate input. The sum bit is propagate combined by exclusive-or with the incoming carry.

The cells are chained from bit 0 upward, so the worst-case delay grows linearly with K. The carry into the most significant cell is brought out as a port. Overflow is taken from the disagreement between that carry and the carry-out.

Top module: `mux_carry_adder`

## Requirements
- R1: `sum_out` equals the low K bits of the unsigned sum `op_a + op_b + carry_in`.
- R2: `carry_out` equals bit K of the unsigned sum `op_a + op_b + carry_in`.
- R3: `ovf_out` is 1 exactly when `op_a[K-1]` equals `op_b[K-1]` and `sum_out[K-1]` differs from them. It is 0 whenever the operand sign bits differ.
- R4: `top_carry` equals the carry into bit K-1, which is bit K-1 of `op_a[K-2:0] + op_b[K-2:0] + carry_in`. `ovf_out` equals `top_carry` XOR `carry_out`.
- R5: When `op_a ^ op_b` is all ones (every cell propagates), `carry_out` equals `carry_in` and every bit of `sum_out` equals the inverse of `carry_in`.
- R6: When `op_a == op_b` (no cell propagates), `carry_out` equals `op_b[K-1]` and `sum_out` equals `{op_a[K-2:0], carry_in}`.
- R7: The block has no clock and no state. After an input change, all outputs show the new result without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | K | First operand |
| op_b | input | K | Second operand; its bit is the generate input of each carry mux |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | K | Sum bits |
| carry_out | output | 1 | Carry out of bit K-1 |
| top_carry | output | 1 | Carry into bit K-1 |
| ovf_out | output | 1 | Two's-complement overflow |

## Verification
The bench builds two copies of the adder side by side, one with K=16 and one with K=4, and drives both from the same operand registers. At K=4 every combination of both operands and the carry-in is applied exhaustively. This covers every overflow case, every carry chain length and both fully-propagating and non-propagating patterns. At K=16, random operands with fixed seeding are mixed with directed corners, such as the largest positive value plus one and the most negative value plus minus one. These show that the chain and the overflow flag scale past the small width.

// File: rtl/mcra_pkg.sv
package mcra_pkg;

    // Smallest operand width for which a carry into the top bit exists
    localparam int MIN_K = 2;

    // The two carries around the most significant cell
    typedef struct packed {
        logic into_msb;
        logic out_of_msb;
    } top_carries_t;

endpackage

// File: rtl/mcra_cell.sv
// One bit position: propagate-steered carry multiplexer plus sum.
module mcra_cell (
    input  logic x_bit,
    input  logic y_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);

    logic prop;

    always_comb begin
        prop  = x_bit ^ y_bit;
        // Propagate passes the incoming carry; otherwise the y bit generates
        // (or kills) the carry.
        c_out = prop ? c_in : y_bit;
        s_bit = prop ^ c_in;
    end

endmodule

// File: rtl/mcra_chain.sv
// Ripple chain of mux-carry cells, bit 0 first.
module mcra_chain #(
    parameter int W = 16
) (
    input  logic                       [W-1:0] a_vec,
    input  logic                       [W-1:0] b_vec,
    input  logic                               c0,
    output logic                       [W-1:0] s_vec,
    output mcra_pkg::top_carries_t             tops
);

    // carry[i] is the carry into bit i; carry[W] leaves the chain
    logic [W:0] carry;

    assign carry[0] = c0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        mcra_cell cell_i (
            .x_bit (a_vec[i]),
            .y_bit (b_vec[i]),
            .c_in  (carry[i]),
            .s_bit (s_vec[i]),
            .c_out (carry[i+1])
        );
    end

    assign tops.into_msb   = carry[W-1];
    assign tops.out_of_msb = carry[W];

endmodule

// File: rtl/mcra_flags.sv
// Carry-out, top carry and signed overflow from the two top carries.
module mcra_flags (
    input  mcra_pkg::top_carries_t tops,
    output logic                   c_out,
    output logic                   c_top,
    output logic                   ovf
);

    always_comb begin
        c_out = tops.out_of_msb;
        c_top = tops.into_msb;
        ovf   = tops.out_of_msb ^ tops.into_msb;
    end

endmodule

// File: rtl/mux_carry_adder.sv
// K-bit ripple adder built from mux-carry cells, with overflow.
module mux_carry_adder #(
    parameter int K = 16
) (
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    input  logic         carry_in,
    output logic [K-1:0] sum_out,
    output logic         carry_out,
    output logic         top_carry,
    output logic         ovf_out
);

    mcra_pkg::top_carries_t tops;

    mcra_chain #(.W(K)) chain_i (
        .a_vec (op_a),
        .b_vec (op_b),
        .c0    (carry_in),
        .s_vec (sum_out),
        .tops  (tops)
    );

    mcra_flags flags_i (
        .tops  (tops),
        .c_out (carry_out),
        .c_top (top_carry),
        .ovf   (ovf_out)
    );

endmodule

// File: rtl/mux_carry_adder_chk.sv
// Port-level checker, bound into every instance of the adder.
module mux_carry_adder_chk #(
    parameter int K = 16
) (
    input logic [K-1:0] op_a,
    input logic [K-1:0] op_b,
    input logic         carry_in,
    input logic [K-1:0] sum_out,
    input logic         carry_out,
    input logic         top_carry,
    input logic         ovf_out
);

    logic [K:0]   full_ref;
    logic [K-1:0] low_ref;

    always_comb begin
        full_ref = {1'b0, op_a} + {1'b0, op_b} + {{K{1'b0}}, carry_in};
        low_ref  = {1'b0, op_a[K-2:0]} + {1'b0, op_b[K-2:0]}
                 + {{(K-1){1'b0}}, carry_in};

        // R1
        sum_value_chk: assert (sum_out == full_ref[K-1:0]);
        // R2
        carry_out_chk: assert (carry_out == full_ref[K]);
        // R3
        sign_rule_chk: assert (ovf_out ==
            ((op_a[K-1] == op_b[K-1]) && (sum_out[K-1] != op_a[K-1])));
        // R4
        top_carry_chk: assert ({top_carry, sum_out[K-2:0]} == low_ref);
        // R5
        if (&(op_a ^ op_b)) begin
            full_prop_chk: assert ((carry_out == carry_in) &&
                                   (sum_out == {K{~carry_in}}));
        end
        // R6
        if (op_a == op_b) begin
            no_prop_chk: assert ((carry_out == op_b[K-1]) &&
                                 (sum_out == {op_a[K-2:0], carry_in}));
        end
    end

endmodule

bind mux_carry_adder mux_carry_adder_chk #(.K(K)) chk_i (.*);

// File: tb/mux_carry_adder_tb_top.sv
module mux_carry_adder_tb_top;

    localparam int WIDE   = 16;
    localparam int NARROW = 4;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    always #10 clk = ~clk;          // 50 MHz

    logic [WIDE-1:0] a_r = '0;
    logic [WIDE-1:0] b_r = '0;
    logic            ci_r = 1'b0;

    logic [WIDE-1:0]   s_w;
    logic              co_w, tc_w, ov_w;
    logic [NARROW-1:0] s_n;
    logic              co_n, tc_n, ov_n;

    mux_carry_adder #(.K(WIDE)) dut_i (
        .op_a (a_r), .op_b (b_r), .carry_in (ci_r),
        .sum_out (s_w), .carry_out (co_w), .top_carry (tc_w), .ovf_out (ov_w)
    );

    mux_carry_adder #(.K(NARROW)) dut_n_i (
        .op_a (a_r[NARROW-1:0]), .op_b (b_r[NARROW-1:0]), .carry_in (ci_r),
        .sum_out (s_n), .carry_out (co_n), .top_carry (tc_n), .ovf_out (ov_n)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] msk(input int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    // Check one instance of width w against a behavioural (w+1)-bit sum
    task automatic check_width(input int w, input logic [63:0] s,
                               input logic co, input logic tc, input logic ov);
        logic [63:0] a, b, full, low;
        logic        e_co, e_tc, e_ov, sa, sb, ss;
        a    = 64'(a_r) & msk(w);
        b    = 64'(b_r) & msk(w);
        full = a + b + 64'(ci_r);
        low  = (a & msk(w-1)) + (b & msk(w-1)) + 64'(ci_r);
        e_co = full[w];
        e_tc = low[w-1];
        sa = a[w-1]; sb = b[w-1]; ss = full[w-1];
        e_ov = (sa == sb) && (ss != sa);
        chk($sformatf("R1 sum w=%0d", w),  s, full & msk(w));
        chk($sformatf("R2 cout w=%0d", w), 64'(co), 64'(e_co));
        chk($sformatf("R3 ovf w=%0d", w),  64'(ov), 64'(e_ov));
        chk($sformatf("R4 top carry w=%0d", w), 64'(tc), 64'(e_tc));
        chk($sformatf("R4 ovf vs carries w=%0d", w), 64'(ov), 64'(e_tc ^ e_co));
    endtask

    task automatic apply(input logic [WIDE-1:0] a, input logic [WIDE-1:0] b,
                         input logic ci);
        @(negedge clk);
        a_r = a; b_r = b; ci_r = ci;
        #5;
        check_width(WIDE, 64'(s_w), co_w, tc_w, ov_w);
        check_width(NARROW, 64'(s_n), co_n, tc_n, ov_n);
    endtask

    initial begin : main
        int unsigned seed_val;
        logic [WIDE-1:0] ra;
        logic            rc;
        seed_val = $urandom(32'h0005EED5);

        // Reset state: all-zero inputs give all-zero outputs
        #5;
        chk("R1 reset sum", 64'(s_w), 64'd0);
        chk("R2 reset cout", 64'(co_w), 64'd0);
        chk("R3 reset ovf", 64'(ov_w), 64'd0);

        // Directed corners at K=16
        apply(16'h7FFF, 16'h0001, 1'b0);   // max positive + 1 -> overflow
        chk("R3 maxpos+1 ovf", 64'(ov_w), 64'd1);
        apply(16'h8000, 16'hFFFF, 1'b0);   // min negative + -1 -> overflow
        chk("R3 minneg-1 ovf", 64'(ov_w), 64'd1);
        chk("R2 minneg-1 cout", 64'(co_w), 64'd1);
        apply(16'h7FFF, 16'h8000, 1'b1);   // mixed signs never overflow
        chk("R3 mixed signs ovf", 64'(ov_w), 64'd0);
        apply(16'hFFFF, 16'h0000, 1'b1);   // ripple through every cell
        chk("R5 full ripple cout", 64'(co_w), 64'd1);
        chk("R5 full ripple sum", 64'(s_w), 64'd0);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        apply(16'h0000, 16'h0000, 1'b1);

        // R5: every cell propagates
        for (int i = 0; i < 40; i++) begin
            ra = WIDE'($urandom);
            rc = 1'($urandom);
            apply(ra, ~ra, rc);
            chk("R5 prop cout", 64'(co_w), 64'(rc));
            chk("R5 prop sum", 64'(s_w), 64'({WIDE{~rc}}));
        end

        // R6: no cell propagates
        for (int i = 0; i < 40; i++) begin
            ra = WIDE'($urandom);
            rc = 1'($urandom);
            apply(ra, ra, rc);
            chk("R6 noprop cout", 64'(co_w), 64'(ra[WIDE-1]));
            chk("R6 noprop sum", 64'(s_w), 64'({ra[WIDE-2:0], rc}));
        end

        // Exhaustive at K=4, random upper bits for the wide copy
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    apply({12'($urandom), 4'(x)}, {12'($urandom), 4'(y)}, 1'(c));
                end
            end
        end

        // Random operands at K=16
        for (int i = 0; i < 1500; i++) begin
            apply(WIDE'($urandom), WIDE'($urandom), 1'($urandom));
        end

        // R7: change inputs mid-cycle, no clock edge before the sample
        @(posedge clk);
        #2;
        a_r = 16'h7FFF; b_r = 16'h7FFF; ci_r = 1'b1;
        #1;
        chk("R7 no-edge sum", 64'(s_w), 64'hFFFF);
        chk("R7 no-edge ovf", 64'(ov_w), 64'd1);
        a_r = 16'h0003; b_r = 16'h0004;
        #1;
        chk("R7 no-edge sum 2", 64'(s_w), 64'h0008);
        chk("R7 no-edge ovf 2", 64'(ov_w), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

endmodule